// File: doc/BRIEF.md
# Cell Transmit Byte Interface

This block streams fixed-size cell payloads from an on-chip transmit FIFO to a PHY-layer device. It uses a byte-wide parallel link that runs on the bus clock. Each enabled cycle carries one data byte. The block raises a start-of-cell marker together with the first byte of every cell, so the PHY can find cell boundaries without counting bytes itself.

The PHY gives an early warning when its buffers are close to full. It raises a full flag at least four cycles before it would actually overflow. The block samples this flag at every clock edge and drops the enable on the very next cycle. It can pause between cells or in the middle of a cell. A cell that was paused resumes at the next byte once the flag clears, and the start-of-cell marker is not raised again for it. The block begins a new cell only when the FIFO reports that a complete cell is waiting. The PHY interrupt line is passed straight through to the host interrupt output.

Top module: `cell_tx_phy`

## Requirements
- R1: Every cycle in which `fifoPop` is high consumes the FIFO head byte. That byte appears on `txData` with `txEnable` high in the following cycle, and bytes leave in FIFO order, one per enabled cycle.
- R2: If `phyFull` is high at a clock edge, `txEnable` is low in the cycle after that edge. No more than four bytes are ever sent while `phyFull` is high.
- R3: If a cell is pending or partly sent, `txEnable` returns high in the first cycle after the first clock edge at which `phyFull` is low.
- R4: `txSoc` is high exactly with the first byte of each cell, is only ever high together with `txEnable`, and is never high for two cycles in a row.
- R5: `hostIrq` equals `phyIrq` at all times, with no register, latch or mask in between.
- R6: A cell is `CELL_BYTES` bytes long (48 by default). The byte after the last byte of a cell is the first byte of the next cell.
- R7: A new cell starts only when `cellAvail` is high. While no cell is partly sent and `cellAvail` is low, `txEnable` stays low.
- R8: When `phyFull` stops a cell after k bytes (0 < k < `CELL_BYTES`), the resumed byte is byte k of the same cell, with `txSoc` low.
- R9: A synchronous active-high `rst` drives `txEnable` and `txSoc` low in the cycle after the edge and clears the byte position. The first byte sent after reset starts a cell.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; also paces the byte link |
| rst | input | 1 | Synchronous active-high reset |
| fifoData | input | DATA_W | Head byte of the transmit FIFO |
| cellAvail | input | 1 | FIFO holds at least one complete cell |
| fifoPop | output | 1 | Consume the head byte this cycle |
| phyFull | input | 1 | Early full warning from the PHY |
| txEnable | output | 1 | A valid byte is on `txData` |
| txSoc | output | 1 | Marks the first byte of a cell |
| txData | output | DATA_W | Byte to the PHY |
| phyIrq | input | 1 | Interrupt request from the PHY |
| hostIrq | output | 1 | Interrupt to the host, equal to `phyIrq` |

## Verification
The embedded assertions check the following on every cycle: full gating of the enable, that a pop is followed by an enabled byte, that the start marker always comes with the enable and never twice in a row, the idle hold when no cell is waiting, the quiet state after reset, and that the byte position stays in range. Other behaviours need whole byte sequences and only the bench scenarios can show them. These are data ordering, the marker landing on byte 0 of each cell, resumption at the correct byte after a stall, and the restart of framing after a reset in the middle of a cell. The bench sweeps a stall of every length from one to four cycles at every byte position of a cell. It also runs a long pseudo-random backpressure pattern and a partial-cell hold.

// File: rtl/cell_tx_pkg.sv
package cell_tx_pkg;

  // Per-cycle strobes from control to the output datapath
  typedef struct packed {
    logic send;   // a byte is taken from the FIFO this cycle
    logic first;  // that byte opens a new cell
  } txStrobe_t;

endpackage

// File: rtl/cell_tx_ctrl.sv
module cell_tx_ctrl
  import cell_tx_pkg::*;
#(
  parameter int CELL_BYTES = 48
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      cellAvail,
  input  logic      phyFull,
  output txStrobe_t strb,
  output logic      cntZero
);

  localparam int CNT_W = $clog2(CELL_BYTES);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(CELL_BYTES - 1);

  logic [CNT_W-1:0] bytePos;
  logic             midCell;
  logic             sendNow;

  assign midCell = (bytePos != '0);
  assign cntZero = !midCell;

  // A started cell is already complete in the FIFO, so only backpressure halts it
  assign sendNow = !rst && !phyFull && (midCell || cellAvail);

  always_comb begin
    strb.send  = sendNow;
    strb.first = sendNow && !midCell;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bytePos <= '0;
    end else if (sendNow) begin
      if (bytePos == LAST_POS) bytePos <= '0;
      else                     bytePos <= bytePos + 1'b1;
    end
  end

  // Byte position never leaves the cell
  assert_pos_in_cell_R6: assert property (@(posedge clk) disable iff (rst)
    int'(bytePos) < CELL_BYTES);

endmodule

// File: rtl/cell_tx_dpath.sv
module cell_tx_dpath
  import cell_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  txStrobe_t         strb,
  input  logic [DATA_W-1:0] fifoData,
  output logic              txEnable,
  output logic              txSoc,
  output logic [DATA_W-1:0] txData
);

  always_ff @(posedge clk) begin
    if (rst) begin
      txEnable <= 1'b0;
      txSoc    <= 1'b0;
      txData   <= '0;
    end else begin
      txEnable <= strb.send;
      txSoc    <= strb.first;
      if (strb.send) txData <= fifoData;
    end
  end

  // Start marker only ever rides on a valid byte
  assert_soc_with_enable_R4: assert property (@(posedge clk) disable iff (rst)
    txSoc |-> txEnable);

endmodule

// File: rtl/cell_tx_phy.sv
module cell_tx_phy
  import cell_tx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CELL_BYTES = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] fifoData,
  input  logic              cellAvail,
  output logic              fifoPop,
  input  logic              phyFull,
  output logic              txEnable,
  output logic              txSoc,
  output logic [DATA_W-1:0] txData,
  input  logic              phyIrq,
  output logic              hostIrq
);

  txStrobe_t strb;
  logic      cntZero;

  cell_tx_ctrl #(.CELL_BYTES(CELL_BYTES)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .cellAvail(cellAvail),
    .phyFull  (phyFull),
    .strb     (strb),
    .cntZero  (cntZero)
  );

  cell_tx_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .fifoData(fifoData),
    .txEnable(txEnable),
    .txSoc   (txSoc),
    .txData  (txData)
  );

  assign fifoPop = strb.send;
  assign hostIrq = phyIrq;

  assert_full_gates_enable_R2: assert property (@(posedge clk) disable iff (rst)
    phyFull |=> !txEnable);

  assert_pop_then_byte_R1: assert property (@(posedge clk) disable iff (rst)
    fifoPop |=> txEnable);

  assert_soc_not_twice_R4: assert property (@(posedge clk) disable iff (rst)
    txSoc |=> !txSoc);

  assert_idle_without_cell_R7: assert property (@(posedge clk) disable iff (rst)
    (cntZero && !cellAvail) |=> !txEnable);

  assert_reset_quiet_R9: assert property (@(posedge clk)
    rst |=> (!txEnable && !txSoc));

endmodule

// File: tb/cell_tx_phy_bench.sv
module cell_tx_phy_bench;
  localparam int PERIOD = 10;
  localparam int QTR    = PERIOD / 4;
  localparam int CELL   = 48;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       phyFull = 1'b0;
  logic       phyIrq = 1'b0;
  logic [7:0] fifoData;
  logic       cellAvail;
  logic       fifoPop, txEnable, txSoc, hostIrq;
  logic [7:0] txData;

  int loaded = 0, rdPtr = 0, expIdx = 0, cellPos = 0, underFull = 0;
  int nTests = 0, nFail = 0;
  bit done = 0;

  cell_tx_phy u_cell_tx_phy (
    .clk(clk), .rst(rst), .fifoData(fifoData), .cellAvail(cellAvail),
    .fifoPop(fifoPop), .phyFull(phyFull), .txEnable(txEnable),
    .txSoc(txSoc), .txData(txData), .phyIrq(phyIrq), .hostIrq(hostIrq)
  );

  function automatic logic [7:0] pat(int i);
    return 8'((i * 7 + 3) & 255);
  endfunction

  assign fifoData  = pat(rdPtr);
  assign cellAvail = (loaded - rdPtr) >= CELL;

  always #(PERIOD/2) clk = ~clk;

  always @(posedge clk) if (fifoPop) rdPtr <= rdPtr + 1;

  task automatic check(bit ok, string req, int act, int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // PHY model: samples a quarter period after each rising edge
  always @(posedge clk) begin
    #QTR;
    if (rst) begin
      cellPos = 0;
    end else if (txEnable) begin
      check(txData == pat(expIdx), "R1 byte order", txData, pat(expIdx));
      check(txSoc == (cellPos == 0), "R4/R6 start marker", txSoc, cellPos == 0);
      expIdx++;
      cellPos = (cellPos + 1) % CELL;
      if (phyFull) begin
        underFull++;
        check(underFull <= 4, "R2 margin", underFull, 4);
      end
    end else if (txSoc) begin
      check(0, "R4 marker without enable", 1, 0);
    end
    if (!phyFull) underFull = 0;
  end

  task automatic waitDrain(string req);
    for (int i = 0; i < 6000 && expIdx != loaded; i++) @(negedge clk);
    check(expIdx == loaded, req, expIdx, loaded);
  endtask

  task automatic runStall(int pos, int len);
    int start;
    start = expIdx;
    loaded += CELL;
    for (int i = 0; i < 200 && (expIdx - start) != pos; i++) @(negedge clk);
    phyFull = 1'b1;
    repeat (len) begin
      @(posedge clk); #QTR;
      check(txEnable == 1'b0, "R2 stall", txEnable, 0);
    end
    @(negedge clk); phyFull = 1'b0;
    @(posedge clk); #QTR;
    check(txEnable == 1'b1, "R3 resume", txEnable, 1);
    if (pos > 0) check(txSoc == 1'b0, "R8 no restart marker", txSoc, 0);
    else         check(txSoc == 1'b1, "R4 first byte marker", txSoc, 1);
    @(negedge clk);
    waitDrain("R8 cell completes");
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", expIdx, loaded);
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    repeat (3) @(negedge clk);
    check(txEnable == 1'b0 && txSoc == 1'b0, "R9 reset outputs", {txEnable, txSoc}, 0);
    rst = 1'b0;

    // R5 pass-through
    phyIrq = 1'b1; #1;
    check(hostIrq == 1'b1, "R5 irq high", hostIrq, 1);
    phyIrq = 1'b0; #1;
    check(hostIrq == 1'b0, "R5 irq low", hostIrq, 0);
    @(negedge clk);

    // R1/R6 back-to-back cells
    loaded += 3 * CELL;
    waitDrain("R6 three cells");

    // R7 partial cell is held
    loaded += CELL - 1;
    repeat (12) @(negedge clk);
    check(expIdx == loaded - (CELL - 1), "R7 partial cell held", expIdx, loaded - (CELL - 1));
    loaded += 1;
    waitDrain("R7 cell released");

    // R2/R3/R8 stall sweep: every position, lengths 1..4
    for (int pos = 0; pos < CELL; pos++)
      for (int len = 1; len <= 4; len++)
        runStall(pos, len);

    // Pseudo-random backpressure over many cells
    lf = 16'hACE1;
    loaded += 20 * CELL;
    for (int i = 0; i < 8000 && expIdx != loaded; i++) begin
      @(negedge clk);
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      phyFull = lf[0] & lf[1];
    end
    phyFull = 1'b0;
    waitDrain("R2 random backpressure");

    // R9 reset in the middle of a cell
    loaded += CELL;
    for (int i = 0; i < 200 && cellPos != 10; i++) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(txEnable == 1'b0 && txSoc == 1'b0, "R9 reset mid-cell", {txEnable, txSoc}, 0);
    rst = 1'b0;
    loaded += 10;
    for (int i = 0; i < 200 && !txEnable; i++) @(negedge clk);
    check(txSoc == 1'b1, "R9 first byte after reset", txSoc, 1);
    waitDrain("R9 drain after reset");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule